// File: doc/BRIEF.md
# Character Cell Video Serializer

This block turns one character code and the current scan line inside a character row into a serial stream of dots for a raster display. The character cell is 7 dots wide and 10 scan lines tall. The block presents a glyph address (the low seven bits of the code plus the scan line) on a lookup port. An external glyph store answers in the same cycle with a 7-bit dot row. On a load strobe, the block applies the display rules to that row, captures the result in a shift register, and then sends one dot per clock, leftmost first.

The display rules depend on the display mode and on whether the graphics option is enabled.

- In the large-format mode, all ten scan lines can be shown. Lines 8 and 9 carry dots only for graphics characters, and only when graphics are enabled.
- In the small-format mode, only the first two scan lines are shown and the other eight are blank.
- A graphics character that arrives while graphics are disabled is never drawn from its glyph. Every dot of the cell is lit at low intensity instead.

An intensity output travels with the dot stream. It tells the video drive whether the current dot run is dark, dim or normal.

Top module: `cell_video_serializer`

## Requirements
- R1: While reset is held and after it is released with no load, `dot_o` is 0 and `intensity_o` is 2'b00.
- R2: `glyph_idx_o` always equals bits 6..0 of `char_code_i`, and `glyph_line_o` always equals `scan_line_i` (combinational, no clock delay).
- R3: A load strobe sampled at clock edge k sets `dot_o` after edge k+i to bit 6−i of the captured row, for i = 0..6. After edge k+7 (with no new load), `dot_o` is 0 and `intensity_o` is 2'b00.
- R4: A character whose code bit 7 is 0, on scan lines 0..7 that the mode shows, is sent as its glyph row at normal intensity (2'b10).
- R5: In the large-format mode (`wide_mode_i`=1), a character with code bit 7 = 0 on scan line 8 or 9 is blank (all dots 0, intensity 2'b00), whatever the value of `gfx_en_i`.
- R6: In the large-format mode with `gfx_en_i`=1, a graphics character (code bit 7 = 1) is sent as its glyph row at normal intensity on every scan line 0..9.
- R7: A graphics character with `gfx_en_i`=0, on any scan line the mode shows, is sent as seven 1 dots at low intensity (2'b01).
- R8: In the small-format mode (`wide_mode_i`=0), scan lines 2..9 are blank for every character. This takes priority over R7.
- R9: Scan line values 10..15 are blank in both modes.
- R10: A load strobe while a row is still shifting discards the remaining dots. The new row starts from its leftmost dot after that edge.
- R11: `intensity_o` only takes the values 2'b00 (off), 2'b01 (low) and 2'b10 (normal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Captures the current character's dot row on this edge |
| char_code_i | input | 8 | Character code; bit 7 marks a graphics character |
| scan_line_i | input | 4 | Scan line within the character row |
| wide_mode_i | input | 1 | 1 = large-format (ten-line) mode, 0 = small-format mode |
| gfx_en_i | input | 1 | Graphics option enabled |
| glyph_idx_o | output | 7 | Glyph lookup index |
| glyph_line_o | output | 4 | Glyph lookup scan line |
| glyph_row_i | input | 7 | Dot row returned by the glyph lookup (bit 6 = leftmost) |
| dot_o | output | 1 | Serial video dot |
| intensity_o | output | 2 | Intensity of the current dot run |

## Verification
The bench sweeps every pairing of mode, graphics enable and all sixteen scan line codes, using text and graphics codes that include the top and bottom glyph indices. This catches a design that lets lines 8 and 9 through for text characters, that forgets the small-format blanking, or that lets the low-intensity fill override mode blanking. Each row is followed past its seventh dot. A counter that is off by one would leave an extra lit dot or a stuck intensity, and a reversed shift would send the rightmost dot first. A reload in the middle of a row checks that a stale tail does not leak into the next character.

// File: rtl/cvs_pkg.sv
// Shared types for the character cell video serializer.
// Assumes: intensity is carried as a two-bit level code.
package cvs_pkg;
    typedef enum logic [1:0] {
        INT_OFF  = 2'b00,
        INT_LOW  = 2'b01,
        INT_NORM = 2'b10
    } intensity_e;
endpackage

// File: rtl/cvs_line_policy.sv
// Decides, for one character on one scan line, which dot row to show and
// at which intensity. It applies mode blanking, graphics suppression with
// low-intensity fill, and the extended-line rule.
// Assumes: glyph_row_i is the lookup answer for the same code and line.
// clk and rst_n are used only by the assertions.
module cvs_line_policy
    import cvs_pkg::*;
#(
    parameter int DOTS          = 7,
    parameter int LINES         = 10,
    parameter int PRIMARY_LINES = 8,
    parameter int NARROW_LINES  = 2,
    parameter int CODE_W        = 8,
    parameter int LINE_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              wide_mode_i,
    input  logic              gfx_en_i,
    input  logic [DOTS-1:0]   glyph_row_i,
    output logic [DOTS-1:0]   row_o,
    output intensity_e        level_o
);
    localparam logic [LINE_W-1:0] CELL_END   = LINE_W'(LINES);
    localparam logic [LINE_W-1:0] PRIM_END   = LINE_W'(PRIMARY_LINES);
    localparam logic [LINE_W-1:0] NARROW_END = LINE_W'(NARROW_LINES);

    logic is_gfx;
    logic line_shown;
    logic line_extended;

    // Classify the character and the scan line.
    always_comb begin
        is_gfx        = code_i[CODE_W-1];
        line_shown    = wide_mode_i ? (line_i < CELL_END) : (line_i < NARROW_END);
        line_extended = (line_i >= PRIM_END);
    end

    // Pick the row and intensity, highest-priority rule first.
    always_comb begin
        if (!line_shown) begin
            row_o   = '0;
            level_o = INT_OFF;
        end else if (is_gfx && !gfx_en_i) begin
            row_o   = '1;
            level_o = INT_LOW;
        end else if (line_extended && !is_gfx) begin
            row_o   = '0;
            level_o = INT_OFF;
        end else begin
            row_o   = glyph_row_i;
            level_o = INT_NORM;
        end
    end

    // Lines past the cell must come out dark.
    assert_cell_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i >= CELL_END) |-> (level_o == INT_OFF && row_o == '0));

    // The low-intensity level always carries a fully lit row.
    assert_low_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == INT_LOW) |-> (row_o == '1));

    // Text characters are never at normal intensity on extended lines.
    assert_text_extended_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_i[CODE_W-1] && line_i >= PRIM_END) |-> (level_o == INT_OFF));

    // The small-format mode shows nothing past its short window.
    assert_narrow_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode_i && line_i >= NARROW_END) |-> (level_o == INT_OFF));
endmodule

// File: rtl/cvs_shifter.sv
// Parallel-load shift register with a dot counter. It sends the captured
// row out leftmost first, one dot per clock, and goes dark after the last dot.
// Assumes: row_i bit DOTS-1 is the leftmost dot; a load restarts the row.
module cvs_shifter
    import cvs_pkg::*;
#(
    parameter int DOTS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [DOTS-1:0] row_i,
    input  intensity_e      level_i,
    output logic            dot_o,
    output intensity_e      level_o
);
    localparam int CNT_W = $clog2(DOTS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DOTS);

    logic [DOTS-1:0]  shreg;
    logic [CNT_W-1:0] remain;
    intensity_e       held_level;

    // Load a new row, or shift one dot per clock while dots remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            remain     <= '0;
            held_level <= INT_OFF;
        end else if (load_i) begin
            shreg      <= row_i;
            remain     <= FULL;
            held_level <= level_i;
        end else if (remain != '0) begin
            shreg  <= {shreg[DOTS-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

    // Drive the current dot and level; dark once the row is used up.
    always_comb begin
        dot_o   = shreg[DOTS-1] && (remain != '0);
        level_o = (remain != '0) ? held_level : INT_OFF;
    end

    // A load always fills the dot counter.
    assert_load_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (remain == FULL));

    // Each shift exposes the dot that was next in line.
    assert_shift_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && remain > CNT_W'(1)) |=> (dot_o == $past(shreg[DOTS-2])));

    // After the final dot, the output goes dark.
    assert_row_end_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && remain == CNT_W'(1)) |=> (!dot_o && level_o == INT_OFF));

    // A reload starts from the new row's leftmost dot.
    assert_reload_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (dot_o == $past(row_i[DOTS-1]) && level_o == $past(level_i)));
endmodule

// File: rtl/cell_video_serializer.sv
// Top of the character cell video serializer. It presents the glyph
// address, applies the display rules to the returned row, and serializes it.
// Assumes: the glyph lookup is combinational and answers in the same cycle.
module cell_video_serializer
    import cvs_pkg::*;
#(
    parameter int DOTS          = 7,
    parameter int LINES         = 10,
    parameter int PRIMARY_LINES = 8,
    parameter int NARROW_LINES  = 2,
    parameter int CODE_W        = 8,
    parameter int LINE_W        = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] char_code_i,
    input  logic [LINE_W-1:0] scan_line_i,
    input  logic              wide_mode_i,
    input  logic              gfx_en_i,
    output logic [CODE_W-2:0] glyph_idx_o,
    output logic [LINE_W-1:0] glyph_line_o,
    input  logic [DOTS-1:0]   glyph_row_i,
    output logic              dot_o,
    output logic [1:0]        intensity_o
);
    logic [DOTS-1:0] shown_row;
    intensity_e      shown_level;
    intensity_e      out_level;

    // Glyph address: index bits of the code plus the scan line.
    always_comb begin
        glyph_idx_o  = char_code_i[CODE_W-2:0];
        glyph_line_o = scan_line_i;
    end

    cvs_line_policy #(
        .DOTS          (DOTS),
        .LINES         (LINES),
        .PRIMARY_LINES (PRIMARY_LINES),
        .NARROW_LINES  (NARROW_LINES),
        .CODE_W        (CODE_W),
        .LINE_W        (LINE_W)
    ) i_policy (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_i      (char_code_i),
        .line_i      (scan_line_i),
        .wide_mode_i (wide_mode_i),
        .gfx_en_i    (gfx_en_i),
        .glyph_row_i (glyph_row_i),
        .row_o       (shown_row),
        .level_o     (shown_level)
    );

    cvs_shifter #(
        .DOTS (DOTS)
    ) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .row_i   (shown_row),
        .level_i (shown_level),
        .dot_o   (dot_o),
        .level_o (out_level)
    );

    // Export the level as its raw two-bit code.
    always_comb intensity_o = out_level;

    // Only the three defined intensity codes reach the port.
    assert_level_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        intensity_o != 2'b11);

    // A lit dot never comes with the off level.
    assert_dot_has_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dot_o |-> (intensity_o != 2'b00));
endmodule

// File: tb/test_cell_video_serializer.sv
`timescale 1ns/1ps
module test_cell_video_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] code = '0;
    logic [3:0] line = '0;
    logic       wide = 1'b1;
    logic       gfx_en = 1'b1;
    logic [6:0] g_idx;
    logic [3:0] g_line;
    logic [6:0] g_row;
    logic       dot;
    logic [1:0] inten;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Reference glyph store: any fixed function of index and line.
    function automatic logic [6:0] glyph_fn(logic [6:0] idx, logic [3:0] ln);
        return 7'(int'(idx) * 5 + int'(ln) * 23 + 1) ^ idx;
    endfunction

    assign g_row = glyph_fn(g_idx, g_line);

    cell_video_serializer i_cell_video_serializer (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .char_code_i  (code),
        .scan_line_i  (line),
        .wide_mode_i  (wide),
        .gfx_en_i     (gfx_en),
        .glyph_idx_o  (g_idx),
        .glyph_line_o (g_line),
        .glyph_row_i  (g_row),
        .dot_o        (dot),
        .intensity_o  (inten)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected row, level and governing rule, from the requirements alone.
    task automatic expect_cell(input logic [7:0] c, input logic [3:0] ln,
                               input bit w, input bit en,
                               output logic [6:0] row, output logic [1:0] lvl,
                               output string tag);
        bit g;
        g = c[7];
        if (ln >= 10) begin
            row = '0; lvl = 2'b00; tag = "R9";
        end else if (!w && ln >= 2) begin
            row = '0; lvl = 2'b00; tag = "R8";
        end else if (g && !en) begin
            row = '1; lvl = 2'b01; tag = "R7";
        end else if (ln >= 8 && !g) begin
            row = '0; lvl = 2'b00; tag = "R5";
        end else begin
            row = glyph_fn(c[6:0], ln); lvl = 2'b10;
            tag = g ? "R6" : "R4";
        end
    endtask

    // Follow a loaded row through its seven dots and the dark tail (R3).
    task automatic follow_row(input logic [6:0] row, input logic [1:0] lvl,
                              input string tag);
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            if (i < 7) begin
                check(dot == row[6-i], tag, $sformatf("dot %0d (R3)", i), dot, row[6-i]);
                check(inten == lvl, tag, $sformatf("level dot %0d", i), inten, lvl);
                check(inten != 2'b11, "R11", "illegal level", inten, lvl);
            end else begin
                check(dot == 1'b0, "R3", "dot after row end", dot, 0);
                check(inten == 2'b00, "R3", "level after row end", inten, 0);
            end
        end
    endtask

    task automatic run_cell(input logic [7:0] c, input logic [3:0] ln,
                            input bit w, input bit en);
        logic [6:0] row;
        logic [1:0] lvl;
        string tag;
        expect_cell(c, ln, w, en, row, lvl, tag);
        @(negedge clk);
        code = c; line = ln; wide = w; gfx_en = en; load = 1'b1;
        #0.5;
        check(g_idx == c[6:0], "R2", "glyph index", g_idx, c[6:0]);
        check(g_line == ln, "R2", "glyph line", g_line, ln);
        @(negedge clk);
        load = 1'b0;
        follow_row(row, lvl, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] codes [6] = '{8'h00, 8'h35, 8'h7F, 8'h80, 8'hA5, 8'hFF};
        logic [6:0] row_a, row_b;
        logic [1:0] lvl_a, lvl_b;
        string tag_a, tag_b;

        // R1: reset state while held and just after release.
        repeat (3) @(negedge clk);
        check(dot == 1'b0 && inten == 2'b00, "R1", "during reset", {inten, dot}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dot == 1'b0 && inten == 2'b00, "R1", "after reset", {inten, dot}, 0);

        // Sweep modes, enable, every scan line code and a set of characters.
        for (int w = 0; w < 2; w++)
            for (int en = 0; en < 2; en++)
                for (int ln = 0; ln < 16; ln++)
                    for (int k = 0; k < 6; k++)
                        run_cell(codes[k], 4'(ln), w[0], en[0]);

        // R10: reload in the middle of a row.
        expect_cell(8'h41, 4'd3, 1'b1, 1'b1, row_a, lvl_a, tag_a);
        expect_cell(8'h12, 4'd4, 1'b1, 1'b1, row_b, lvl_b, tag_b);
        @(negedge clk);
        code = 8'h41; line = 4'd3; wide = 1'b1; gfx_en = 1'b1; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            check(dot == row_a[6-i], "R10", $sformatf("first row dot %0d", i), dot, row_a[6-i]);
        end
        code = 8'h12; line = 4'd4; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        follow_row(row_b, lvl_b, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule